// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block keeps a single up/down position count that advances in one of four selectable ways: once per clock cycle as a plain timer, or from a two-channel quadrature encoder (channels A and B) by counting edges of A only, edges of B only, or edges of both channels. In the quadrature modes the block works out the direction of each step from the level of the other channel. It shows the direction of the most recent step on a flag.

The count wraps inside a programmable range from 0 to a ceiling value. Stepping up from the ceiling gives 0, and stepping down from 0 gives the ceiling. The encoder inputs are asynchronous. They pass through a synchroniser before the edges are detected.

Software drives the block through a write strobe with a 2-bit address and a data word. It can set an enable bit, load the ceiling, and load the count. A load of the count is refused if the value is above the ceiling. It can also stage a new counting mode, which only becomes active on an update-event strobe. The active configuration and the count are visible on output ports.

Top module: `enc_quad_counter`

## Requirements
- R1: After reset the count is 0, the ceiling is all ones, the active mode is 0 (clock mode), the enable flag is 0 and the direction flag is 0.
- R2: In mode 0, while enabled, the count rises by exactly one each clock cycle, and activity on A and B has no effect.
- R3: In mode 1, each rising or falling edge of A moves the count by one, and edges of B move it not at all. An A edge counts up when the new level of A differs from the level of B, and counts down otherwise.
- R4: In mode 2, each edge of B moves the count by one, and edges of A move it not at all. A B edge counts up when the new level of B equals the level of A, and counts down otherwise.
- R5: In mode 3, every edge of A or B moves the count by one. The order (B,A) = 00, 01, 11, 10, 00 counts up, and the reverse order counts down.
- R6: The direction flag becomes 1 after a step down and 0 after a step up. It holds its value between steps, so it stays 0 in mode 0.
- R7: An up step taken when the count is at or above the ceiling gives 0. A down step taken from 0 gives the ceiling.
- R8: Writing address 0 sets the enable flag from data bit 0. While the enable flag is 0 the count holds in every mode, and writes are still accepted.
- R9: Writing address 1 stages a mode taken from data bits [1:0]. The active mode, shown on `mode_o`, changes only on an `update_i` pulse. If the mode write and the pulse come in the same cycle, the value being written is applied.
- R10: Writing address 3 loads the ceiling, and the new ceiling governs wrapping and load checks from the next cycle on.
- R11: Writing address 2 loads the count in the next cycle when the value is at most the current ceiling. A larger value is refused and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Write address: 0 enable, 1 mode, 2 count, 3 ceiling |
| wdata_i | input | CNT_W | Write data |
| update_i | input | 1 | Update-event pulse that applies the staged mode |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| count_o | output | CNT_W | Current count |
| ceiling_o | output | CNT_W | Current ceiling |
| mode_o | output | 2 | Active counting mode |
| enable_o | output | 1 | Enable flag |
| dir_o | output | 1 | Direction of the last step, 1 = down |

## Verification
The bench runs the full Gray cycle forward and backward in each quadrature mode.
- A decoder that mixes up the channel roles counts edges of the wrong channel.
- A decoder that inverts the direction rule moves the count the wrong way and shows the wrong direction flag.

Three wrap and load cases are covered:
- Wrap up at the ceiling: an off-by-one compare lands on ceiling+1 instead of 0.
- Wrap down below 0: this exposes an underflow to all ones.
- Loading a count above the ceiling: a missing range check lets the value through.

The bench also checks that a staged mode has no effect before the update pulse. It checks that a disabled counter holds while A and B toggle, which catches an enable that gates only one step path.

// File: rtl/enc_pkg.sv
package enc_pkg;
  typedef enum logic [1:0] {
    MODE_CLK = 2'd0,
    MODE_X2A = 2'd1,
    MODE_X2B = 2'd2,
    MODE_X4  = 2'd3
  } enc_mode_e;

  typedef enum logic [1:0] {
    ADR_CTRL  = 2'd0,
    ADR_MODE  = 2'd1,
    ADR_COUNT = 2'd2,
    ADR_CEIL  = 2'd3
  } enc_addr_e;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/enc_edge_dec.sv
module enc_edge_dec
  import enc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a_i,
  input  logic      b_i,
  input  enc_mode_e mode_i,
  output logic      step_up_o,
  output logic      step_dn_o
);
  logic a_prev_q, b_prev_q;
  logic a_chg, b_chg, a_fwd, b_fwd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_i;
      b_prev_q <= b_i;
    end
  end

  assign a_chg = a_i ^ a_prev_q;
  assign b_chg = b_i ^ b_prev_q;
  // A leads B on forward motion
  assign a_fwd = a_i ^ b_i;
  assign b_fwd = ~(a_i ^ b_i);

  always_comb begin
    step_up_o = 1'b0;
    step_dn_o = 1'b0;
    unique case (mode_i)
      MODE_CLK: step_up_o = 1'b1;
      MODE_X2A: if (a_chg && !b_chg) begin
        step_up_o = a_fwd;
        step_dn_o = ~a_fwd;
      end
      MODE_X2B: if (b_chg && !a_chg) begin
        step_up_o = b_fwd;
        step_dn_o = ~b_fwd;
      end
      MODE_X4: if (a_chg ^ b_chg) begin
        step_up_o = a_chg ? a_fwd : b_fwd;
        step_dn_o = a_chg ? ~a_fwd : ~b_fwd;
      end
      default: ;
    endcase
  end

  p_one_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_up_o, step_dn_o}));
  p_clk_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CLK) |-> (step_up_o && !step_dn_o));
  p_x2a_b_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_X2A && $stable(a_i)) |-> !(step_up_o || step_dn_o));
  p_x2b_a_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_X2B && $stable(b_i)) |-> !(step_up_o || step_dn_o));
endmodule

// File: rtl/enc_regs.sv
module enc_regs
  import enc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             update_i,
  output logic             enable_o,
  output enc_mode_e        mode_o,
  output logic [CNT_W-1:0] ceil_o
);
  enc_mode_e mode_pend_q, mode_act_q;
  logic      wr_mode;

  assign wr_mode = wr_i && (addr_i == ADR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o    <= 1'b0;
      ceil_o      <= '1;
      mode_pend_q <= MODE_CLK;
      mode_act_q  <= MODE_CLK;
    end else begin
      if (wr_i && addr_i == ADR_CTRL) enable_o <= wdata_i[0];
      if (wr_i && addr_i == ADR_CEIL) ceil_o <= wdata_i;
      if (wr_mode) mode_pend_q <= enc_mode_e'(wdata_i[1:0]);
      if (update_i) mode_act_q <= wr_mode ? enc_mode_e'(wdata_i[1:0]) : mode_pend_q;
    end
  end

  assign mode_o = mode_act_q;

  p_mode_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(mode_act_q));
  p_ceil_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADR_CEIL) |=> (ceil_o == $past(wdata_i)));
endmodule

// File: rtl/enc_count_core.sv
module enc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] count_q;
  logic             load_ok;

  assign load_ok = load_i && (load_val_i <= ceil_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      dir_o   <= 1'b0;
    end else begin
      if (load_ok) count_q <= load_val_i;
      else if (en_i && step_up_i) count_q <= (count_q >= ceil_i) ? '0 : count_q + 1'b1;
      else if (en_i && step_dn_i) count_q <= (count_q == '0) ? ceil_i : count_q - 1'b1;
      if (en_i && step_up_i) dir_o <= 1'b0;
      else if (en_i && step_dn_i) dir_o <= 1'b1;
    end
  end

  assign count_o = count_q;

  p_hold_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_q));
  p_reject_big_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i > ceil_i && !en_i) |=> $stable(count_q));
  p_wrap_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_up_i && !load_i && count_q >= ceil_i) |=> (count_q == '0));
  p_wrap_dn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_dn_i && !load_i && count_q == '0) |=> (count_q == $past(ceil_i)));
  p_dir_dn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_dn_i) |=> dir_o);
endmodule

// File: rtl/enc_quad_counter.sv
module enc_quad_counter
  import enc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             update_i,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] ceiling_o,
  output logic [1:0]       mode_o,
  output logic             enable_o,
  output logic             dir_o
);
  logic [1:0] ab_sync;
  enc_mode_e  mode_act;
  logic       step_up, step_dn, enable;
  logic [CNT_W-1:0] ceil;

  enc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({enc_b_i, enc_a_i}),
    .q_o   (ab_sync)
  );

  enc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .update_i(update_i),
    .enable_o(enable),
    .mode_o  (mode_act),
    .ceil_o  (ceil)
  );

  enc_edge_dec u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (ab_sync[0]),
    .b_i      (ab_sync[1]),
    .mode_i   (mode_act),
    .step_up_o(step_up),
    .step_dn_o(step_dn)
  );

  enc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable),
    .step_up_i (step_up),
    .step_dn_i (step_dn),
    .ceil_i    (ceil),
    .load_i    (wr_i && addr_i == ADR_COUNT),
    .load_val_i(wdata_i),
    .count_o   (count_o),
    .dir_o     (dir_o)
  );

  assign ceiling_o = ceil;
  assign mode_o    = mode_act;
  assign enable_o  = enable;
endmodule

// File: tb/enc_quad_counter_bench.sv
module enc_quad_counter_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic upd = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic [CNT_W-1:0] count, ceiling;
  logic [1:0] mode;
  logic enable, dir;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  enc_quad_counter #(.CNT_W(CNT_W)) u_enc_quad_counter (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .update_i(upd), .enc_a_i(enc_a), .enc_b_i(enc_b), .count_o(count),
    .ceiling_o(ceiling), .mode_o(mode), .enable_o(enable), .dir_o(dir)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    wr_reg(2'd1, CNT_W'(m));
    pulse_upd();
  endtask

  // change A/B then let sync + edge logic settle
  task automatic drive_ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 ceiling", ceiling, 65535);
    chk("R1 mode", mode, 0);
    chk("R1 enable", enable, 0);
    chk("R1 dir", dir, 0);
  endtask

  task automatic t_clock_mode();
    int c0;
    wr_reg(2'd3, 16'd1000);
    wr_reg(2'd2, 16'd0);
    wr_reg(2'd0, 16'd1);
    c0 = count;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      enc_a = ~enc_a;
      if (i % 3 == 0) enc_b = ~enc_b;
    end
    chk("R2 clock count +10 with A/B toggling", count, c0 + 10);
    chk("R6 dir up in clock mode", dir, 0);
    wr_reg(2'd0, 16'd0);
    c0 = count;
    repeat (6) @(negedge clk);
    chk("R8 hold while disabled", count, c0);
    enc_a = 1'b0; enc_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_wrap_up();
    wr_reg(2'd3, 16'd5);
    wr_reg(2'd2, 16'd3);
    wr_reg(2'd0, 16'd1);
    chk("R7 start", count, 3);
    repeat (2) @(negedge clk);
    chk("R7 at ceiling", count, 5);
    @(negedge clk);
    chk("R7 wrap to zero", count, 0);
    @(negedge clk);
    chk("R7 after wrap", count, 1);
    wr_reg(2'd0, 16'd0);
  endtask

  task automatic t_load();
    int c0;
    wr_reg(2'd3, 16'd5);
    wr_reg(2'd2, 16'd2);
    chk("R11 load within ceiling", count, 2);
    c0 = count;
    wr_reg(2'd2, 16'd7);
    chk("R11 load above ceiling refused", count, c0);
    wr_reg(2'd2, 16'd5);
    chk("R11 load equal to ceiling", count, 5);
    wr_reg(2'd3, 16'd9);
    chk("R10 ceiling readback", ceiling, 9);
    wr_reg(2'd2, 16'd7);
    chk("R10 new ceiling used at once", count, 7);
  endtask

  task automatic t_mode_pending();
    int c0;
    wr_reg(2'd3, 16'd1000);
    wr_reg(2'd2, 16'd0);
    wr_reg(2'd1, 16'd3);
    chk("R9 staged mode not active", mode, 0);
    wr_reg(2'd0, 16'd1);
    c0 = count;
    repeat (5) @(negedge clk);
    chk("R9 still clock counting", count, c0 + 5);
    wr_reg(2'd0, 16'd0);
    pulse_upd();
    chk("R9 mode applied by update", mode, 3);
    @(negedge clk);
    wr = 1'b1; addr = 2'd1; wdata = 16'd2; upd = 1'b1;
    @(negedge clk);
    wr = 1'b0; upd = 1'b0;
    chk("R9 write with update same cycle", mode, 2);
  endtask

  task automatic t_x2a();
    set_mode(2'd1);
    wr_reg(2'd3, 16'd100);
    wr_reg(2'd2, 16'd10);
    wr_reg(2'd0, 16'd1);
    drive_ab(1, 0); chk("R3 A rise fwd", count, 11);
    drive_ab(1, 1); chk("R3 B edge ignored", count, 11);
    drive_ab(0, 1); chk("R3 A fall fwd", count, 12);
    chk("R6 dir after up", dir, 0);
    drive_ab(0, 0); chk("R3 B fall ignored", count, 12);
    drive_ab(0, 1); chk("R3 B rise ignored", count, 12);
    drive_ab(1, 1); chk("R3 A rise rev", count, 11);
    chk("R6 dir after down", dir, 1);
    drive_ab(1, 0); drive_ab(0, 0);
    chk("R3 A fall rev", count, 10);
    chk("R6 dir holds between steps", dir, 1);
    wr_reg(2'd0, 16'd0);
  endtask

  task automatic t_x2b();
    set_mode(2'd2);
    wr_reg(2'd2, 16'd20);
    wr_reg(2'd0, 16'd1);
    drive_ab(1, 0); chk("R4 A rise ignored", count, 20);
    drive_ab(1, 1); chk("R4 B rise fwd", count, 21);
    drive_ab(0, 1); chk("R4 A fall ignored", count, 21);
    drive_ab(0, 0); chk("R4 B fall fwd", count, 22);
    drive_ab(0, 1); chk("R4 B rise rev", count, 21);
    chk("R6 dir down x2b", dir, 1);
    wr_reg(2'd0, 16'd0);
    drive_ab(0, 0);
  endtask

  task automatic t_x4();
    set_mode(2'd3);
    wr_reg(2'd3, 16'd7);
    wr_reg(2'd2, 16'd2);
    wr_reg(2'd0, 16'd1);
    drive_ab(1, 0); drive_ab(1, 1); drive_ab(0, 1); drive_ab(0, 0);
    chk("R5 forward cycle +4", count, 6);
    chk("R6 dir up x4", dir, 0);
    drive_ab(0, 1); drive_ab(1, 1); drive_ab(1, 0); drive_ab(0, 0);
    chk("R5 reverse cycle -4", count, 2);
    chk("R6 dir down x4", dir, 1);
    wr_reg(2'd2, 16'd0);
    drive_ab(0, 1);
    chk("R7 wrap down to ceiling", count, 7);
    wr_reg(2'd0, 16'd0);
    drive_ab(1, 1); drive_ab(1, 0);
    chk("R8 disabled x4 holds", count, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clock_mode();
    t_wrap_up();
    t_load();
    t_mode_pending();
    t_x2a();
    t_x2b();
    t_x4();
    summary();
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule